// File: doc/BRIEF.md
# Then/Else Predication Sequencer

This unit sits at the register-fetch point of an in-order pipeline. It decides, for each decoded instruction, whether that instruction executes or is turned into a NOP. Cancelled instructions are not removed. They keep their slot and travel on with a kill bit set, so predication never redirects fetch.

A predicate-setting instruction carries three things: a condition bit, a shadow length of up to eight, and a letter mask with one letter for each following instruction. The unit holds the mask and consumes one letter for every later instruction it accepts. When the held condition is true, instructions whose letter is "then" run and "else" instructions are killed. When the condition is false, the two roles swap. A new predicate replaces whatever part of the shadow is still left. Outside the shadow, and on top of it, an instruction may carry its own tag that tests a single status flag. That flag is copied to a save slot on interrupt entry and copied back on interrupt return.

Top module: `pred_seq_top`

## Requirements
- R1: After reset, outValid and outKill are 0, flagOut is 0 and no shadow is active.
- R2: An instruction accepted while inValid=1 and stall=0 appears on outValid/outKill on the next clock edge. A killed instruction still shows outValid=1, with outKill=1. Only a valid output can be killed.
- R3: predMask bit k (k=0 is the first following instruction) set to 1 marks a then-instruction and 0 marks an else-instruction. With predCond=1, then-instructions execute and else-instructions are killed.
- R4: With predCond=0, else-instructions execute and then-instructions are killed.
- R5: Each accepted non-predicate instruction in the shadow consumes exactly one letter. The shadow lasts predLen instructions, and a predLen above 8 acts as 8.
- R6: A predicate accepted while a shadow is still active discards the remaining letters and starts its own mask.
- R7: While stall=1 no letter is consumed and outValid/outKill hold their values.
- R8: flush=1 clears the active shadow and makes outValid 0 on the next edge. Instructions that follow are not masked.
- R9: Once the shadow is exhausted, untagged instructions execute (outKill=0).
- R10: predTag=1 executes only if the status flag is 1, and predTag=2 executes only if it is 0. Codes 0 and 3 are untagged. Inside a shadow, a tag kill and a letter kill combine with OR.
- R11: flagWr loads flagWrVal into the flag. irqEnter saves the flag. irqReturn restores the saved value, and this restore takes priority over flagWr.
- R12: The predicate instruction itself is never killed and consumes no letter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction present at register fetch |
| stall | input | 1 | Pipeline hold |
| flush | input | 1 | Pipeline flush |
| isPred | input | 1 | Instruction is a predicate setter |
| predCond | input | 1 | Condition carried by the predicate |
| predLen | input | 4 | Shadow length (number of letters) |
| predMask | input | 8 | Letter mask, bit 0 first, 1 = then |
| predTag | input | 2 | Per-instruction flag tag |
| flagWr | input | 1 | Write the status flag |
| flagWrVal | input | 1 | Value to write |
| irqEnter | input | 1 | Save the flag |
| irqReturn | input | 1 | Restore the flag |
| outValid | output | 1 | Registered valid of the instruction |
| outKill | output | 1 | Registered kill (convert to NOP) |
| flagOut | output | 1 | Current status flag |

## Verification
The letter logic is exercised with mixed then/else masks under both condition polarities, so a swapped polarity or a wrong bit order gives different kill patterns. An all-else mask of clamped length 15 tests the count limit and the first instruction after the shadow ends. A replacement predicate issued in the middle of an all-else shadow shows whether leftover letters leak past it. Further sequences apply a tag inside a shadow, stall and flush in the middle of a shadow, and a flag save/restore across an interrupt, to separate shift, hold, clear and restore behaviour.

// File: rtl/pred_seq_pkg.sv
package pred_seq_pkg;
  localparam int MASK_MAX = 8;
  localparam int CNT_W    = $clog2(MASK_MAX + 1);

  typedef enum logic [1:0] {
    TAG_NONE     = 2'd0,
    TAG_IF_TRUE  = 2'd1,
    TAG_IF_FALSE = 2'd2,
    TAG_RSVD     = 2'd3
  } predTag_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic clear;
  } maskStrobe_t;
endpackage

// File: rtl/pred_seq_dp.sv
module pred_seq_dp
  import pred_seq_pkg::*;
#(
  parameter int MaskMax = MASK_MAX,
  parameter int CntW    = CNT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  maskStrobe_t        strb,
  input  logic [MaskMax-1:0] newMask,
  input  logic [CntW-1:0]    newLen,
  input  logic               newCond,
  input  logic               flagWr,
  input  logic               flagWrVal,
  input  logic               irqEnter,
  input  logic               irqReturn,
  output logic               curLetter,
  output logic               maskActive,
  output logic               condHeld,
  output logic               flagBit
);
  localparam logic [CntW-1:0] LenLimit = CntW'(MaskMax);

  logic [MaskMax-1:0] maskReg;
  logic [CntW-1:0]    cntReg;
  logic               savedFlag;
  logic [CntW-1:0]    lenClamped;

  assign lenClamped = (newLen > LenLimit) ? LenLimit : newLen;
  assign curLetter  = maskReg[0];
  assign maskActive = (cntReg != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg  <= '0;
      cntReg   <= '0;
      condHeld <= 1'b0;
    end else if (strb.clear) begin
      maskReg <= '0;
      cntReg  <= '0;
    end else if (strb.load) begin
      maskReg  <= newMask;
      cntReg   <= lenClamped;
      condHeld <= newCond;
    end else if (strb.shift) begin
      maskReg <= maskReg >> 1;
      cntReg  <= cntReg - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagBit   <= 1'b0;
      savedFlag <= 1'b0;
    end else begin
      if (irqEnter) savedFlag <= flagBit;
      if (irqReturn)   flagBit <= savedFlag;
      else if (flagWr) flagBit <= flagWrVal;
    end
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    cntReg <= LenLimit);
  p_shift_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shift && !strb.clear && !strb.load) |=> cntReg == $past(cntReg) - 1'b1);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.shift && !strb.clear && !strb.load) |=> $stable(cntReg) && $stable(maskReg));
  p_restore_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqReturn |=> flagBit == $past(savedFlag));
endmodule

// File: rtl/pred_seq_ctrl.sv
module pred_seq_ctrl
  import pred_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        stall,
  input  logic        flush,
  input  logic        isPred,
  input  logic [1:0]  predTag,
  input  logic        curLetter,
  input  logic        maskActive,
  input  logic        condHeld,
  input  logic        flagBit,
  output maskStrobe_t strb,
  output logic        outValid,
  output logic        outKill
);
  logic accept;
  logic maskKill;
  logic tagKill;
  logic killNow;

  assign accept   = inValid && !stall;
  assign maskKill = maskActive && (curLetter != condHeld);

  always_comb begin
    unique case (predTag_e'(predTag))
      TAG_IF_TRUE:  tagKill = !flagBit;
      TAG_IF_FALSE: tagKill = flagBit;
      default:      tagKill = 1'b0;
    endcase
  end

  assign killNow = !isPred && (maskKill || tagKill);

  always_comb begin
    strb.clear = flush;
    strb.load  = accept && isPred && !flush;
    strb.shift = accept && !isPred && maskActive && !flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      outValid <= 1'b0;
      outKill  <= 1'b0;
    end else if (!stall) begin
      outValid <= inValid;
      outKill  <= inValid && killNow;
    end
  end

  p_kill_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    outKill |-> outValid);
  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !outValid);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !flush) |=> $stable(outValid) && $stable(outKill));
  p_pred_alive_r12: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isPred && !flush) |=> !outKill);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.shift}));
endmodule

// File: rtl/pred_seq_top.sv
module pred_seq_top
  import pred_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                stall,
  input  logic                flush,
  input  logic                isPred,
  input  logic                predCond,
  input  logic [CNT_W-1:0]    predLen,
  input  logic [MASK_MAX-1:0] predMask,
  input  logic [1:0]          predTag,
  input  logic                flagWr,
  input  logic                flagWrVal,
  input  logic                irqEnter,
  input  logic                irqReturn,
  output logic                outValid,
  output logic                outKill,
  output logic                flagOut
);
  maskStrobe_t strb;
  logic curLetter;
  logic maskActive;
  logic condHeld;

  pred_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stall(stall), .flush(flush),
    .isPred(isPred), .predTag(predTag), .curLetter(curLetter),
    .maskActive(maskActive), .condHeld(condHeld), .flagBit(flagOut),
    .strb(strb), .outValid(outValid), .outKill(outKill)
  );

  pred_seq_dp #(.MaskMax(MASK_MAX), .CntW(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .newMask(predMask), .newLen(predLen),
    .newCond(predCond), .flagWr(flagWr), .flagWrVal(flagWrVal),
    .irqEnter(irqEnter), .irqReturn(irqReturn), .curLetter(curLetter),
    .maskActive(maskActive), .condHeld(condHeld), .flagBit(flagOut)
  );
endmodule

// File: tb/tb_pred_seq_top.sv
`timescale 1ns/1ps
module tb_pred_seq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 0, stall = 0, flush = 0, isPred = 0, predCond = 0;
  logic [3:0] predLen = 0;
  logic [7:0] predMask = 0;
  logic [1:0] predTag = 0;
  logic flagWr = 0, flagWrVal = 0, irqEnter = 0, irqReturn = 0;
  logic outValid, outKill, flagOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pred_seq_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stall(stall), .flush(flush),
    .isPred(isPred), .predCond(predCond), .predLen(predLen), .predMask(predMask),
    .predTag(predTag), .flagWr(flagWr), .flagWrVal(flagWrVal),
    .irqEnter(irqEnter), .irqReturn(irqReturn),
    .outValid(outValid), .outKill(outKill), .flagOut(flagOut)
  );

  always #4 clk = ~clk;

  // vector: {isPred, cond, len[3:0], mask[7:0], tag[1:0], expKill}
  localparam int NV = 28;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1,1'b1,4'd3,8'b00000101,2'd0,1'b0}, // 0 pred true T,E,T (R12)
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b0},        // 1 T runs (R3)
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b1},        // 2 E killed (R3)
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b0},        // 3 T runs
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b0},        // 4 exhausted (R9)
    {1'b1,1'b0,4'd2,8'b00000001,2'd0,1'b0}, // 5 pred false T,E
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b1},        // 6 T killed (R4)
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b0},        // 7 E runs (R4)
    {1'b0,1'b0,4'd0,8'd0,2'd1,1'b1},        // 8 if-true, flag 0 (R10)
    {1'b0,1'b0,4'd0,8'd0,2'd2,1'b0},        // 9 if-false, flag 0 (R10)
    {1'b1,1'b1,4'd4,8'b00000000,2'd0,1'b0}, // 10 pred true all E
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b1},        // 11 E killed
    {1'b1,1'b1,4'd2,8'b00000011,2'd0,1'b0}, // 12 replace (R6)
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b0},        // 13
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b0},        // 14
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b0},        // 15 old leftover would kill (R6)
    {1'b1,1'b1,4'd15,8'b00000000,2'd0,1'b0},// 16 len 15 clamps to 8 (R5)
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b1},
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b1},
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b1},
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b1},
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b1},
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b1},
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b1},
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b1},        // 24 eighth letter
    {1'b0,1'b0,4'd0,8'd0,2'd0,1'b0},        // 25 ninth runs (R5)
    {1'b1,1'b1,4'd1,8'b00000001,2'd0,1'b0}, // 26 pred one T
    {1'b0,1'b0,4'd0,8'd0,2'd1,1'b1}         // 27 T but tag kills (R10)
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic p, input logic c,
                      input logic [3:0] l, input logic [7:0] m, input logic [1:0] t);
    inValid = v; isPred = p; predCond = c; predLen = l; predMask = m; predTag = t;
    @(posedge clk); @(negedge clk);
    inValid = 0; isPred = 0; predTag = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outValid", outValid, 1'b0);
    check("R1 outKill", outKill, 1'b0);
    check("R1 flagOut", flagOut, 1'b0);
    rstN = 1;
    @(negedge clk);
    step(1, 0, 0, 0, 0, 0);
    check("R1 no shadow", outKill, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(1, VEC[i][16], VEC[i][15], VEC[i][14:11], VEC[i][10:3], VEC[i][2:1]);
      check($sformatf("R2 valid vec %0d", i), outValid, 1'b1);
      check($sformatf("R3/R4 kill vec %0d", i), outKill, VEC[i][0]);
    end

    // R2: bubble gives no valid
    step(0, 0, 0, 0, 0, 0);
    check("R2 bubble", outValid, 1'b0);

    // R7: stall holds, consumes nothing
    step(1, 1, 1, 4'd2, 8'b00000010, 0);   // E then T
    stall = 1;
    step(1, 0, 0, 0, 0, 0);
    check("R7 hold valid", outValid, 1'b1);
    check("R7 hold kill", outKill, 1'b0);
    step(1, 0, 0, 0, 0, 0);
    stall = 0;
    step(1, 0, 0, 0, 0, 0);
    check("R7 first letter kept", outKill, 1'b1);
    step(1, 0, 0, 0, 0, 0);
    check("R7 second letter", outKill, 1'b0);

    // R8: flush clears shadow
    step(1, 1, 1, 4'd3, 8'b00000000, 0);
    flush = 1;
    step(1, 0, 0, 0, 0, 0);
    flush = 0;
    check("R8 valid cleared", outValid, 1'b0);
    step(1, 0, 0, 0, 0, 0);
    check("R8 shadow gone", outKill, 1'b0);

    // R11: flag write, save, restore
    flagWr = 1; flagWrVal = 1;
    @(posedge clk); @(negedge clk);
    flagWr = 0;
    check("R11 write", flagOut, 1'b1);
    step(1, 0, 0, 0, 0, 2'd1);
    check("R10 if-true flag 1", outKill, 1'b0);
    irqEnter = 1;
    @(posedge clk); @(negedge clk);
    irqEnter = 0;
    flagWr = 1; flagWrVal = 0;
    @(posedge clk); @(negedge clk);
    check("R11 cleared", flagOut, 1'b0);
    irqReturn = 1; flagWrVal = 0;
    @(posedge clk); @(negedge clk);
    irqReturn = 0; flagWr = 0;
    check("R11 restore wins", flagOut, 1'b1);
    step(1, 0, 0, 0, 0, 2'd2);
    check("R10 if-false flag 1", outKill, 1'b1);
    step(1, 0, 0, 0, 0, 2'd3);
    check("R10 code 3 untagged", outKill, 1'b0);

    finishRun();
  end
endmodule